// File: doc/BRIEF.md
# Periodic Interrupt Rate Generator

This block turns a 32.768 kHz timebase into a periodic tick. The timebase arrives as a one-cycle enable pulse in the system clock domain. A free-running binary prescaler counts those pulses. A 4-bit rate code chooses how many low prescaler bits must all be ones when a pulse arrives; that pulse becomes a tick. Each tick sets a sticky periodic flag. The flag drives the interrupt request only while the periodic enable input is high.

Software writes a byte-wide control register. It carries the rate code in bits [3:0] and a prescaler hold bit in bit 6. While the hold bit is set, the prescaler stays at zero. When the hold bit is released, a clean full period follows before the first tick. The rate code may change at any time. The new code is judged against the prescaler value already reached, so the prescaler is not restarted.

Top module: `prg_periodic_gen`

## Requirements
- R1: After reset the control register reads 0x00, the flag is 0 and the interrupt request is 0. A rate code of 0 is therefore active and the prescaler runs.
- R2: A cycle with `ctl_wr` high loads `ctl_wdata` into the control register. `ctl_rdata` returns the whole stored byte from the next cycle on.
- R3: For rate codes 3 to 15, the tick period is 2^(code-1) timebase pulses. Code 3 gives 4 pulses (1/8192 s) and code 15 gives 16384 pulses (1/2 s).
- R4: Rate code 1 gives a period of 128 pulses (1/256 s) and rate code 2 gives 256 pulses (1/128 s). These are the same periods as codes 8 and 9.
- R5: With rate code 0 no tick occurs and the flag never sets.
- R6: While control bit 6 is 1, the prescaler is held at zero and no tick occurs. After the bit is cleared, the first tick comes on the Pth timebase pulse, where P is the selected period.
- R7: A tick sets the flag on the clock edge that takes in that timebase pulse, whatever the state of `pie_en`. The flag then stays set until it is cleared.
- R8: `flag_clr` clears the flag at the next edge. If a tick happens in the same cycle, the tick wins and the flag stays set.
- R9: `pirq` is high exactly when the flag is set and `pie_en` is high.
- R10: A tick occurs on a timebase pulse when the low (period-exponent) bits of the running prescaler are all ones. After a rate change, ticks line up with the prescaler value already reached. There is no restart.
- R11: The prescaler advances by one only on cycles with `tb_en` high. Cycles without a pulse neither advance it nor produce a tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tb_en | input | 1 | One-cycle pulse at 32.768 kHz |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control write data: [3:0] rate code, [6] prescaler hold |
| ctl_rdata | output | 8 | Control register contents |
| pie_en | input | 1 | Periodic interrupt enable |
| flag_clr | input | 1 | Clears the periodic flag |
| pflag | output | 1 | Sticky periodic flag |
| pirq | output | 1 | Periodic interrupt request |

## Verification
The assertions assume that `tb_en` is a single-cycle qualifier sampled only at clock edges. They also assume that control writes, clears and the enable are steady around each edge. They assume nothing about spacing, so back-to-back pulses, long gaps and writes that land on a tick cycle are all legal. The stimulus changes every input only at the falling clock edge. It mixes directed runs with `tb_en` high on every cycle against random runs in which pulses, writes, clears and the enable are drawn from a seeded generator. In this way holds, rate changes and clear-versus-tick collisions each occur many times.

// File: rtl/prg_pkg.sv
package prg_pkg;

  localparam int unsigned RATE_W   = 4;
  localparam int unsigned CTL_W    = 8;
  localparam int unsigned HOLD_BIT = 6;

  // Number of low prescaler bits that must all be ones for a tick.
  // A result of zero means the tick is switched off.
  function automatic int unsigned rate_width(input logic [RATE_W-1:0] code);
    int unsigned w;
    case (code)
      4'd0:    w = 0;
      4'd1:    w = 7;
      4'd2:    w = 8;
      default: w = int'(code) - 1;
    endcase
    return w;
  endfunction

  // Period of the tick in timebase pulses for a given code.
  function automatic int unsigned rate_period(input logic [RATE_W-1:0] code);
    int unsigned w;
    w = rate_width(code);
    return (w == 0) ? 0 : (32'd1 << w);
  endfunction

endpackage

// File: rtl/prg_ctrl_reg.sv
module prg_ctrl_reg
  import prg_pkg::*;
#(
  parameter int unsigned W = CTL_W,
  parameter int unsigned HB = HOLD_BIT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [W-1:0]      wdata,
  output logic [W-1:0]      q,
  output logic [RATE_W-1:0] rate,
  output logic              hold
);

  logic [W-1:0] store;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  store <= '0;
    else if (wr) store <= wdata;
  end

  assign q    = store;
  assign rate = store[RATE_W-1:0];
  assign hold = store[HB];

endmodule

// File: rtl/prg_divider.sv
module prg_divider #(
  parameter int unsigned DIV_W = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step_en,
  input  logic             hold,
  output logic [DIV_W-1:0] cnt
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= '0;
    else if (hold)    cnt <= '0;
    else if (step_en) cnt <= cnt + 1'b1;
  end

endmodule

// File: rtl/prg_tick_sel.sv
module prg_tick_sel
  import prg_pkg::*;
#(
  parameter int unsigned DIV_W = 15
) (
  input  logic [DIV_W-1:0]  cnt,
  input  logic [RATE_W-1:0] rate,
  input  logic              step_en,
  input  logic              hold,
  output logic              tick
);

  localparam int unsigned SEL_W = $clog2(DIV_W + 1);

  // full[w] is high when the low w prescaler bits are all ones.
  logic [DIV_W:0] full;
  assign full[0] = 1'b0;

  genvar g;
  generate
    for (g = 1; g <= DIV_W; g++) begin : g_full
      assign full[g] = &cnt[g-1:0];
    end
  endgenerate

  int unsigned      w_int;
  logic [SEL_W-1:0] w_sel;
  logic             in_range;

  always_comb begin
    w_int    = rate_width(rate);
    in_range = (w_int != 0) && (w_int <= DIV_W);
    w_sel    = in_range ? SEL_W'(w_int) : '0;
    tick     = step_en && !hold && in_range && full[w_sel];
  end

endmodule

// File: rtl/prg_flag.sv
module prg_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic flag
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   flag <= 1'b0;
    else if (set) flag <= 1'b1;
    else if (clr) flag <= 1'b0;
  end

endmodule

// File: rtl/prg_periodic_gen.sv
module prg_periodic_gen
  import prg_pkg::*;
#(
  parameter int unsigned DIV_W = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tb_en,
  input  logic             ctl_wr,
  input  logic [CTL_W-1:0] ctl_wdata,
  output logic [CTL_W-1:0] ctl_rdata,
  input  logic             pie_en,
  input  logic             flag_clr,
  output logic             pflag,
  output logic             pirq
);

  logic [RATE_W-1:0] rate_code;
  logic              div_hold;
  logic [DIV_W-1:0]  div_cnt;
  logic              tick;

  prg_ctrl_reg #(.W(CTL_W), .HB(HOLD_BIT)) u_ctrl (
    .clk   (clk),
    .rst_n (rst_n),
    .wr    (ctl_wr),
    .wdata (ctl_wdata),
    .q     (ctl_rdata),
    .rate  (rate_code),
    .hold  (div_hold)
  );

  prg_divider #(.DIV_W(DIV_W)) u_div (
    .clk     (clk),
    .rst_n   (rst_n),
    .step_en (tb_en),
    .hold    (div_hold),
    .cnt     (div_cnt)
  );

  prg_tick_sel #(.DIV_W(DIV_W)) u_sel (
    .cnt     (div_cnt),
    .rate    (rate_code),
    .step_en (tb_en),
    .hold    (div_hold),
    .tick    (tick)
  );

  prg_flag u_flag (
    .clk   (clk),
    .rst_n (rst_n),
    .set   (tick),
    .clr   (flag_clr),
    .flag  (pflag)
  );

  assign pirq = pflag & pie_en;

endmodule

// File: rtl/prg_periodic_chk.sv
module prg_periodic_chk #(
  parameter int unsigned DIV_W = 15
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tb_en,
  input logic             pie_en,
  input logic             flag_clr,
  input logic             div_hold,
  input logic [3:0]       rate_code,
  input logic [DIV_W-1:0] div_cnt,
  input logic             tick,
  input logic             pflag,
  input logic             pirq
);

  a_r11_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    (tb_en && !div_hold) |=> div_cnt == DIV_W'($past(div_cnt) + 1'b1));

  a_r11_count_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!tb_en && !div_hold) |=> $stable(div_cnt));

  a_r11_tick_on_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> tb_en);

  a_r6_hold_zero: assert property (@(posedge clk) disable iff (!rst_n)
    div_hold |=> div_cnt == '0);

  a_r6_hold_no_tick: assert property (@(posedge clk) disable iff (!rst_n)
    div_hold |-> !tick);

  a_r5_code0_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (rate_code == 4'd0) |-> !tick);

  a_r7_tick_sets: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> pflag);

  a_r7_rise_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pflag) |-> $past(tick));

  a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr && !tick) |=> !pflag);

  a_r9_irq_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
    pirq |-> (pie_en && pflag));

endmodule

bind prg_periodic_gen prg_periodic_chk #(.DIV_W(DIV_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .tb_en     (tb_en),
  .pie_en    (pie_en),
  .flag_clr  (flag_clr),
  .div_hold  (div_hold),
  .rate_code (rate_code),
  .div_cnt   (div_cnt),
  .tick      (tick),
  .pflag     (pflag),
  .pirq      (pirq)
);

// File: tb/tb_prg_periodic_gen.sv
module tb_prg_periodic_gen;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tb_en = 1'b0;
  logic       ctl_wr = 1'b0;
  logic [7:0] ctl_wdata = 8'h00;
  logic [7:0] ctl_rdata;
  logic       pie_en = 1'b0;
  logic       flag_clr = 1'b0;
  logic       pflag;
  logic       pirq;

  int total = 0;
  int bad = 0;

  // bench model
  logic [14:0] m_cnt = '0;
  logic [7:0]  m_ctl = '0;
  logic        m_flag = 1'b0;

  always #10 clk = ~clk;

  prg_periodic_gen dut (
    .clk(clk), .rst_n(rst_n), .tb_en(tb_en), .ctl_wr(ctl_wr),
    .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata), .pie_en(pie_en),
    .flag_clr(flag_clr), .pflag(pflag), .pirq(pirq)
  );

  // Period in pulses, taken from the rate table of R3, R4 and R5.
  function automatic int period_of(input logic [3:0] c);
    if (c == 0) return 0;
    if (c == 1) return 128;
    if (c == 2) return 256;
    return 4 << (int'(c) - 3);
  endfunction

  task automatic check_bit(input logic act, input logic exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got %0b expected %0b", tag, act, exp);
    end
  endtask

  task automatic check_int(input int act, input int exp, input string tag);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  // One cycle: drive at falling edge, advance model, compare after edge.
  task automatic step(input logic en, input logic wr, input logic [7:0] wd,
                      input logic pie, input logic clr, input string tag);
    int  p;
    logic tk;
    @(negedge clk);
    tb_en = en; ctl_wr = wr; ctl_wdata = wd; pie_en = pie; flag_clr = clr;
    p  = period_of(m_ctl[3:0]);
    tk = en && !m_ctl[6] && (p != 0) && ((int'(m_cnt) % p) == p - 1);
    m_flag = tk ? 1'b1 : (clr ? 1'b0 : m_flag);
    m_cnt  = m_ctl[6] ? 15'd0 : (en ? m_cnt + 15'd1 : m_cnt);
    if (wr) m_ctl = wd;
    @(posedge clk);
    #1;
    total++;
    if (pflag !== m_flag || pirq !== (m_flag & pie) || ctl_rdata !== m_ctl) begin
      bad++;
      $display("FAIL %s: flag=%0b irq=%0b ctl=%h expected flag=%0b irq=%0b ctl=%h",
               tag, pflag, pirq, ctl_rdata, m_flag, m_flag & pie, m_ctl);
    end
  endtask

  task automatic idle(input logic en, input logic pie, input string tag);
    step(en, 1'b0, 8'h00, pie, 1'b0, tag);
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: run did not finish, got timeout expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    int n;
    logic [31:0] seed;
    seed = 32'd20240611;
    void'($urandom(seed));

    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    check_bit(pflag, 1'b0, "R1 flag at reset");
    check_bit(pirq, 1'b0, "R1 irq at reset");
    check_int(int'(ctl_rdata), 0, "R1 control at reset");
    @(negedge clk);
    rst_n = 1'b1;

    // R2: write and read back whole byte
    step(1'b0, 1'b1, 8'hA5, 1'b0, 1'b0, "R2 write A5");
    check_int(int'(ctl_rdata), 8'hA5, "R2 readback A5");
    step(1'b0, 1'b1, 8'hBF, 1'b0, 1'b0, "R2 write BF");
    check_int(int'(ctl_rdata), 8'hBF, "R2 readback BF");

    // R3, R4, R6: first tick after release arrives P pulses later (pie off for R7)
    for (int c = 1; c < 16; c++) begin
      step(1'b1, 1'b1, 8'h40 | 8'(c), 1'b0, 1'b1, "R6 hold");
      step(1'b1, 1'b1, 8'(c), 1'b0, 1'b1, "R6 release");
      n = 0;
      while (!pflag && n < 20000) begin
        idle(1'b1, 1'b0, (c < 3) ? "R4 run" : "R3 run");
        n++;
      end
      check_int(n, period_of(4'(c)), (c < 3) ? "R4 period" : "R3 R6 period");
      check_bit(pirq, 1'b0, "R7 flag set with enable low");
    end
    // R9: enable gates the request
    idle(1'b0, 1'b1, "R9 enable on");
    check_bit(pirq, 1'b1, "R9 irq with flag and enable");

    // R8: tick and clear together -> flag stays set
    step(1'b1, 1'b1, 8'h43, 1'b1, 1'b1, "R8 hold");
    step(1'b1, 1'b1, 8'h03, 1'b1, 1'b0, "R8 release");
    idle(1'b1, 1'b1, "R8 run");
    idle(1'b1, 1'b1, "R8 run");
    idle(1'b1, 1'b1, "R8 run");
    step(1'b1, 1'b0, 8'h00, 1'b1, 1'b1, "R8 collide");
    check_bit(pflag, 1'b1, "R8 tick wins over clear");
    step(1'b0, 1'b0, 8'h00, 1'b1, 1'b1, "R8 clear");
    check_bit(pflag, 1'b0, "R8 clear alone");

    // R5: code 0 never ticks
    step(1'b1, 1'b1, 8'h00, 1'b1, 1'b1, "R5 select off");
    for (int i = 0; i < 2000; i++) idle(1'b1, 1'b1, "R5 off run");
    check_bit(pflag, 1'b0, "R5 no flag with code 0");

    // R11: gaps in the timebase freeze the prescaler
    step(1'b1, 1'b1, 8'h43, 1'b0, 1'b1, "R11 hold");
    step(1'b1, 1'b1, 8'h03, 1'b0, 1'b0, "R11 release");
    idle(1'b1, 1'b0, "R11 run");
    idle(1'b1, 1'b0, "R11 run");
    idle(1'b1, 1'b0, "R11 run");
    for (int i = 0; i < 50; i++) idle(1'b0, 1'b0, "R11 gap");
    check_bit(pflag, 1'b0, "R11 no tick during gap");
    idle(1'b1, 1'b0, "R11 resume");
    check_bit(pflag, 1'b1, "R11 tick on next pulse");

    // R10: rate change keeps the running prescaler
    step(1'b1, 1'b1, 8'h4F, 1'b0, 1'b1, "R10 hold");
    step(1'b1, 1'b1, 8'h0F, 1'b0, 1'b0, "R10 release");
    for (int i = 0; i < 5; i++) idle(1'b1, 1'b0, "R10 slow");
    step(1'b1, 1'b1, 8'h03, 1'b0, 1'b0, "R10 switch");
    idle(1'b1, 1'b0, "R10 after switch");
    check_bit(pflag, 1'b0, "R10 count 6 no tick");
    idle(1'b1, 1'b0, "R10 after switch");
    check_bit(pflag, 1'b1, "R10 tick at count 7");

    // Random mix (R2, R6, R7, R8, R9, R10, R11 via model)
    for (int i = 0; i < 5000; i++) begin
      logic en, wr, pie, clr;
      logic [7:0] wd;
      en  = ($urandom % 2) == 0;
      wr  = ($urandom % 40) == 0;
      clr = ($urandom % 16) == 0;
      pie = ($urandom % 3) != 0;
      wd  = 8'($urandom);
      if (($urandom % 4) != 0) wd[6] = 1'b0;
      if (($urandom % 2) == 0) wd[3:0] = 4'($urandom % 6);
      step(en, wr, wd, pie, clr, "R10 random");
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule